// File: doc/BRIEF.md
# Cascadable Preset Binary Counter

This block is a synchronous up-counter built from 4-bit slices. Each slice holds a nibble that can be zeroed, preset from parallel data, advanced by one, or held. All of these happen on the rising clock edge. Clearing and presetting are synchronous, active low, and override the count enables. Two enables gate counting. The first is a plain enable shared by every slice. The second is a chain enable that also qualifies the slice's carry-out. Because of that, slices chain into a wider counter with no extra gating.

The top module stacks `STAGES` slices. The chain enable entering slice 0 comes from the port. Each later slice takes the carry of the slice below it as its chain enable. The wide carry-out is the carry of the top slice.

With `MOD_EN` set, a comparator watches the count for `TERM_VALUE` and folds a match into the clear. The counter then cycles through `TERM_VALUE + 1` states.

Top module: `cnt_chain`

## Requirements
- R1: With both enables high and no clear or load, the `4*STAGES`-bit count rises by exactly one per rising edge. All bits change at the same edge, and the count wraps from all ones to zero.
- R2: When `sclr_n` is 0 at a rising edge, the count is zero after that edge. This holds whatever `pload_n`, `cnt_en` and `chain_en` are, so clear wins over load.
- R3: When `pload_n` is 0 and `sclr_n` is 1 at a rising edge, the count equals `din` after that edge, whatever the enables are. Any value may be preset.
- R4: With `sclr_n` and `pload_n` both 1, the count advances only when `cnt_en` and `chain_en` are both 1. Otherwise it holds its value.
- R5: `carry_out` is 1 exactly when the count is all ones and `chain_en` is 1. It is combinational and follows `chain_en` without a clock edge.
- R6: Changes on `cnt_en`, `chain_en` or `pload_n` between edges leave the stored count untouched until the next rising edge.
- R7: A slice advances only when every slice below it reads 15 (4'b1111) and counting is enabled. For example, 0x0F goes to 0x10, and the upper nibble holds at other times.
- R8: With `MOD_EN` = 1, a count equal to `TERM_VALUE` at a rising edge becomes zero after that edge, whatever the enables or load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for every slice |
| sclr_n | input | 1 | Synchronous clear, active low |
| pload_n | input | 1 | Synchronous parallel preset, active low |
| cnt_en | input | 1 | Count enable shared by all slices |
| chain_en | input | 1 | Count enable that also gates the carry-out |
| din | input | 4*STAGES | Preset data |
| count | output | 4*STAGES | Current count |
| carry_out | output | 1 | High while the count is all ones and `chain_en` is high |

## Verification
Each start value is preset and then followed by every one of the sixteen combinations of clear, load and the two enables. This separates the clear-over-load priority from the load-over-count priority and from the hold cases. Start values at nibble and modulus boundaries check that a carry crosses slices only when the lower slice is full. A long free run compares a plain instance and a modulus instance against their arithmetic models, through the wrap of the full width and the early return to zero. Two further patterns run inside a single low clock phase: toggling the enables and load, and toggling the chain enable. These separate combinational carry behaviour from registered count behaviour. A long random run then mixes all controls.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    localparam int NIB_W = 4;
    localparam logic [NIB_W-1:0] NIB_ONE = 1;

    typedef enum logic [1:0] {
        OP_CLEAR,
        OP_LOAD,
        OP_COUNT,
        OP_HOLD
    } op_e;

    typedef struct packed {
        logic [NIB_W-1:0] val;
    } nib_state_t;
endpackage

// File: rtl/cnt_nibble.sv
module cnt_nibble
    import cnt_pkg::*;
(
    input  logic             clk,
    input  logic             sclr_n,
    input  logic             pload_n,
    input  logic             cnt_en,
    input  logic             chain_en,
    input  logic [NIB_W-1:0] din,
    output logic [NIB_W-1:0] q,
    output logic             carry
);
    nib_state_t st_d, st_q;
    op_e        op;

    // Priority of operations: clear, then load, then count.
    always_comb begin
        if (!sclr_n)                   op = OP_CLEAR;
        else if (!pload_n)             op = OP_LOAD;
        else if (cnt_en && chain_en)   op = OP_COUNT;
        else                           op = OP_HOLD;

        st_d = st_q;
        unique case (op)
            OP_CLEAR: st_d.val = '0;
            OP_LOAD:  st_d.val = din;
            OP_COUNT: st_d.val = st_q.val + NIB_ONE;
            default:  st_d     = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q     = st_q.val;
    // Carry look-ahead: full nibble, qualified only by the chain enable.
    assign carry = (&st_q.val) & chain_en;
endmodule

// File: rtl/cnt_term_dec.sv
module cnt_term_dec #(
    parameter int          W          = 8,
    parameter int unsigned TERM_VALUE = 99
) (
    input  logic [W-1:0] count,
    input  logic         sclr_n,
    output logic         sclr_eff_n
);
    localparam logic [W-1:0] TERM_W = TERM_VALUE[W-1:0];

    // A match on the terminal value acts like a pulled-low clear.
    assign sclr_eff_n = sclr_n & (count != TERM_W);
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
    import cnt_pkg::*;
#(
    parameter int          STAGES     = 2,
    parameter bit          MOD_EN     = 1'b0,
    parameter int unsigned TERM_VALUE = 99
) (
    input  logic                      clk,
    input  logic                      sclr_n,
    input  logic                      pload_n,
    input  logic                      cnt_en,
    input  logic                      chain_en,
    input  logic [STAGES*NIB_W-1:0]   din,
    output logic [STAGES*NIB_W-1:0]   count,
    output logic                      carry_out
);
    localparam int W = STAGES * NIB_W;

    logic [STAGES:0] ena_chain;
    logic            clr_eff_n;

    assign ena_chain[0] = chain_en;

    generate
        if (MOD_EN) begin : g_mod
            cnt_term_dec #(
                .W          (W),
                .TERM_VALUE (TERM_VALUE)
            ) u_dec (
                .count      (count),
                .sclr_n     (sclr_n),
                .sclr_eff_n (clr_eff_n)
            );
        end else begin : g_plain
            assign clr_eff_n = sclr_n;
        end
    endgenerate

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            cnt_nibble u_nib (
                .clk      (clk),
                .sclr_n   (clr_eff_n),
                .pload_n  (pload_n),
                .cnt_en   (cnt_en),
                .chain_en (ena_chain[k]),
                .din      (din[k*NIB_W +: NIB_W]),
                .q        (count[k*NIB_W +: NIB_W]),
                .carry    (ena_chain[k+1])
            );
        end
    endgenerate

    assign carry_out = ena_chain[STAGES];
endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk #(
    parameter int          W          = 8,
    parameter bit          MOD_EN     = 1'b0,
    parameter int unsigned TERM_VALUE = 99
) (
    input logic         clk,
    input logic         sclr_n,
    input logic         pload_n,
    input logic         cnt_en,
    input logic         chain_en,
    input logic [W-1:0] din,
    input logic [W-1:0] count,
    input logic         carry_out
);
    localparam logic [W-1:0] TERM_W = TERM_VALUE[W-1:0];

    // The count is unknown until a first clear has been applied.
    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        if (!sclr_n) armed <= 1'b1;
    end

    logic term_hit;
    assign term_hit = MOD_EN && (count == TERM_W);

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!armed)
        !sclr_n |=> count == '0); // R2

    AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!armed)
        (sclr_n && !pload_n && !term_hit) |=> count == $past(din)); // R3

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!armed)
        (sclr_n && pload_n && cnt_en && chain_en && !term_hit)
        |=> count == $past(count) + 1'b1); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!armed)
        (sclr_n && pload_n && !(cnt_en && chain_en) && !term_hit)
        |=> $stable(count)); // R4

    AST_CARRY_FULL: assert property (@(posedge clk) disable iff (!armed)
        carry_out == ((&count) && chain_en)); // R5

    AST_TERM_WRAP: assert property (@(posedge clk) disable iff (!armed)
        term_hit |=> count == '0); // R8
endmodule

bind cnt_chain cnt_chain_chk #(
    .W          (W),
    .MOD_EN     (MOD_EN),
    .TERM_VALUE (TERM_VALUE)
) u_chk (
    .clk       (clk),
    .sclr_n    (sclr_n),
    .pload_n   (pload_n),
    .cnt_en    (cnt_en),
    .chain_en  (chain_en),
    .din       (din),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/tb_cnt_chain.sv
module tb_cnt_chain;
    localparam int STAGES = 2;
    localparam int W      = 4 * STAGES;
    localparam int MASK   = (1 << W) - 1;
    localparam int TERM   = 99;

    logic         clk = 1'b0;
    logic         sclr_n, pload_n, cnt_en, chain_en;
    logic [W-1:0] din;
    logic [W-1:0] count_a, count_b;
    logic         carry_a, carry_b;

    int checks = 0;
    int errors = 0;
    int ma = 0;
    int mb = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cnt_chain #(.STAGES(STAGES), .MOD_EN(1'b0), .TERM_VALUE(TERM)) dut (
        .clk(clk), .sclr_n(sclr_n), .pload_n(pload_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .din(din), .count(count_a), .carry_out(carry_a));

    cnt_chain #(.STAGES(STAGES), .MOD_EN(1'b1), .TERM_VALUE(TERM)) dut_mod (
        .clk(clk), .sclr_n(sclr_n), .pload_n(pload_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .din(din), .count(count_b), .carry_out(carry_b));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int nxt(input int cur, input bit modm);
        if (!sclr_n || (modm && cur == TERM)) return 0;
        if (!pload_n) return int'(din);
        if (cnt_en && chain_en) return (cur + 1) & MASK;
        return cur;
    endfunction

    task automatic step(input string tag_a, input string tag_b);
        @(posedge clk);
        ma = nxt(ma, 1'b0);
        mb = nxt(mb, 1'b1);
        @(negedge clk);
        check(int'(count_a) == ma, tag_a, int'(count_a), ma);
        check(int'(count_b) == mb, tag_b, int'(count_b), mb);
        check(carry_a == ((ma == MASK) && chain_en), "R5", int'(carry_a),
              int'((ma == MASK) && chain_en));
        check(carry_b == ((mb == MASK) && chain_en), "R5", int'(carry_b),
              int'((mb == MASK) && chain_en));
    endtask

    task automatic drive(input bit c, input bit l, input bit p, input bit t, input int d);
        sclr_n = c; pload_n = l; cnt_en = p; chain_en = t; din = W'(d);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int starts[8] = '{0, 7, 14, 15, 255, 15, 99, 98};
        drive(1'b0, 1'b1, 1'b1, 1'b1, 0);
        @(negedge clk);
        step("R2", "R2");

        // Every control combination after each preset value.
        foreach (starts[i]) begin
            for (int combo = 0; combo < 16; combo++) begin
                string tg;
                @(negedge clk);
                drive(1'b1, 1'b0, combo[1], combo[0], starts[i]);
                step("R3", "R8");
                drive(combo[3], combo[2], combo[1], combo[0], (~starts[i]) & MASK);
                if (!combo[3])      tg = "R2";
                else if (!combo[2]) tg = "R3";
                else                tg = "R4";
                step(tg, (starts[i] == TERM) ? "R8" : tg);
            end
        end

        // Carry crossing a slice boundary.
        drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h0E);
        step("R3", "R3");
        drive(1'b1, 1'b1, 1'b1, 1'b1, 0);
        step("R7", "R7");
        step("R7", "R7");
        check(count_a == 8'h10, "R7", int'(count_a), 16);

        // Mid-phase toggling has no effect on the stored count.
        drive(1'b1, 1'b0, 1'b0, 1'b0, 5);
        step("R3", "R3");
        #1 cnt_en = 1'b1; chain_en = 1'b1;
        #1 cnt_en = 1'b0; pload_n = 1'b0; din = 8'hAA;
        #1 pload_n = 1'b1;
        check(count_a == 8'd5, "R6", int'(count_a), 5);
        step("R6", "R6");

        // Combinational carry follows the chain enable without a clock.
        drive(1'b1, 1'b0, 1'b0, 1'b1, 255);
        step("R3", "R3");
        chain_en = 1'b0;
        #1 check(carry_a == 1'b0, "R5", int'(carry_a), 0);
        chain_en = 1'b1;
        #1 check(carry_a == 1'b1, "R5", int'(carry_a), 1);
        check(count_a == 8'hFF, "R5", int'(count_a), 255);

        // Free run through full-width wrap and modulus wrap.
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 0);
        step("R2", "R2");
        sclr_n = 1'b1;
        for (int n = 0; n < 600; n++) step("R1", "R8");

        // Random mix of all controls.
        for (int n = 0; n < 3000; n++) begin
            drive(($urandom % 16) != 0, ($urandom % 8) != 0,
                  ($urandom % 4) != 0, ($urandom % 4) != 0, int'($urandom % 256));
            step("R4", "R8");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule